// File: doc/BRIEF.md
# Color Bar and Overlay Source Selector

This block sits at the head of a video encoder's pixel path. On every pixel clock it chooses one of three sources and drives a single Y/U/V sample toward modulation. The three sources are the live picture, a flat overlay color, and an internally generated eight-bar test pattern. The generated colors come from a built-in eight-entry table of saturated ITU-601 colors. A two-bit level field scales them in quarter steps. The bar edges are fixed sample positions chosen by a three-bit video-mode code.

The caller supplies the horizontal sample counter of the current line. The block locates that sample within the line of the selected mode. A small source state machine names what the output shows in the next cycle:
- `SRC_LIVE`: pass-through of the live samples.
- `SRC_OVL`: overlay color.
- `SRC_BAR`: test bar.
- `SRC_BLANK`: black.

Every state can move to every other state on the next clock. The target state depends only on the inputs sampled at that edge:
- Bar enable high moves to `SRC_BAR` inside the active window and to `SRC_BLANK` outside it.
- Bar enable low with overlay enable high moves to `SRC_OVL` inside the window and to `SRC_BLANK` outside it.
- Both enables low move to `SRC_LIVE`.

Reset enters `SRC_BLANK`.

Top module: `cbar_ovl_sel`

## Requirements
- R1: While reset is asserted, the outputs are black: Y=16, U=0, V=0, with U and V in two's complement.
- R2: The output has exactly one clock of latency. The sample seen after a rising edge reflects the inputs sampled at that edge, on every path, including the live path.
- R3: Source priority is fixed.
  - Bar enable high outputs the bar pattern whatever the overlay enable is.
  - Otherwise, overlay enable high outputs the overlay color.
  - Otherwise, the live input passes through.
- R4: On the live path, Y passes unchanged. The offset-binary Cb and Cr inputs become two's complement U and V by inverting bit 7.
- R5: The bars run left to right in this order: white, yellow, cyan, green, magenta, red, blue, black. Bar n covers samples from edge n up to one sample before edge n+1. Edge 0 is the window start and edge 8 is the line length.
- R6: The edges per mode code are fixed:
  - 000: start 127; edges 216/305/394/483/572/661/750; length 858.
  - 001: start 116; edges 197/278/359/440/521/602/682; length 780.
  - 010: start 135; edges 230/325/419/513/607/701/795; length 910.
  - 100: start 142; edges 230/318/406/494/582/670/757; length 864.
  - 101: start 155; edges 251/347/443/539/635/731/827; length 944.
  - Codes 011, 110 and 111 behave as 000.
- R7: When the bar or overlay source is selected and the counter is below the start or at or above the line length, the output is black (16/0/0).
- R8: The overlay color index is {red,green,blue}. The 100% values (Y,U,V) for each index are:
  - 0: 16/0/0
  - 1: 41/112/-18
  - 2: 145/-74/-94
  - 3: 170/38/-112
  - 4: 81/-38/112
  - 5: 106/74/94
  - 6: 210/-112/18
  - 7: 235/0/0
  - The bars use these same entries.
- R9: Let k = level+1, so level 00/01/10/11 gives k = 1/2/3/4 (25/50/75/100%). Generated samples are scaled as follows:
  - Y' = 16 + floor((Y-16)*k/4).
  - U' = floor(U*k/4) and V' = floor(V*k/4), rounding toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | HCNT_W | Sample index within the current line |
| mode | input | 3 | Video-mode code (R6) |
| ovl_r | input | 1 | Overlay red bit |
| ovl_g | input | 1 | Overlay green bit |
| ovl_b | input | 1 | Overlay blue bit |
| ovl_en | input | 1 | Overlay enable |
| bar_en | input | 1 | Test-bar enable |
| lvl | input | 2 | Generated-color level |
| y_in | input | 8 | Live luminance |
| cb_in | input | 8 | Live Cb, offset binary |
| cr_in | input | 8 | Live Cr, offset binary |
| y_out | output | 8 | Selected luminance |
| u_out | output | 8 | Selected U, two's complement |
| v_out | output | 8 | Selected V, two's complement |

## Verification
The hardest situation to reach is the exact sample on either side of each bar edge, in all five modes. In normal use the counter sweeps a whole line, so a single-sample slip would hide among hundreds of correct samples. The stimulus therefore drives the counter directly to each edge, one sample before each edge, the window start minus one, the last sample of the line and the line length itself, in every mode. The three unused mode codes are also checked against the first mode at the same positions.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

    localparam int NUM_BARS  = 8;
    localparam int BAR_IDX_W = $clog2(NUM_BARS);
    localparam int EDGE_W    = 16;
    localparam logic [7:0] BLACK_Y = 8'd16;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] u;
        logic [7:0] v;
    } yuv_t;

    typedef enum logic [1:0] {
        SRC_LIVE,
        SRC_OVL,
        SRC_BAR,
        SRC_BLANK
    } src_e;

    // Edge k of a mode: k=0 window start, 1..7 bar boundaries, 8 line length.
    function automatic logic [EDGE_W-1:0] bar_edge(input logic [2:0] mode,
                                                   input logic [3:0] k);
        logic [EDGE_W-1:0] t [9];
        case (mode)
            3'b001:  t = '{16'd116, 16'd197, 16'd278, 16'd359, 16'd440,
                           16'd521, 16'd602, 16'd682, 16'd780};
            3'b010:  t = '{16'd135, 16'd230, 16'd325, 16'd419, 16'd513,
                           16'd607, 16'd701, 16'd795, 16'd910};
            3'b100:  t = '{16'd142, 16'd230, 16'd318, 16'd406, 16'd494,
                           16'd582, 16'd670, 16'd757, 16'd864};
            3'b101:  t = '{16'd155, 16'd251, 16'd347, 16'd443, 16'd539,
                           16'd635, 16'd731, 16'd827, 16'd944};
            default: t = '{16'd127, 16'd216, 16'd305, 16'd394, 16'd483,
                           16'd572, 16'd661, 16'd750, 16'd858};
        endcase
        return (k < 4'd9) ? t[k] : '0;
    endfunction

    // Bar position to color index {r,g,b}.
    function automatic logic [2:0] bar_to_rgb(input logic [BAR_IDX_W-1:0] idx);
        case (idx)
            3'd0:    return 3'b111;
            3'd1:    return 3'b110;
            3'd2:    return 3'b011;
            3'd3:    return 3'b010;
            3'd4:    return 3'b101;
            3'd5:    return 3'b100;
            3'd6:    return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    // Full-level Y, U, V (U,V two's complement) per color index {r,g,b}.
    function automatic yuv_t rgb_to_yuv(input logic [2:0] rgb);
        case (rgb)
            3'b111:  return {8'd235, 8'h00, 8'h00};
            3'b110:  return {8'd210, 8'h90, 8'h12};
            3'b011:  return {8'd170, 8'h26, 8'h90};
            3'b010:  return {8'd145, 8'hB6, 8'hA2};
            3'b101:  return {8'd106, 8'h4A, 8'h5E};
            3'b100:  return {8'd81,  8'hDA, 8'h70};
            3'b001:  return {8'd41,  8'h70, 8'hEE};
            default: return {8'd16,  8'h00, 8'h00};
        endcase
    endfunction

endpackage

// File: rtl/cbar_locator.sv
module cbar_locator
    import cbar_pkg::*;
#(
    parameter int HCNT_W = 10
) (
    input  logic [HCNT_W-1:0]    hcount,
    input  logic [2:0]           mode,
    output logic                 win_active,
    output logic [BAR_IDX_W-1:0] bar_idx
);

    localparam int CMP_W = (HCNT_W > EDGE_W) ? HCNT_W : EDGE_W;

    logic [CMP_W-1:0]    h_ext;
    logic [NUM_BARS-2:0] past_edge;

    assign h_ext = CMP_W'(hcount);

    for (genvar k = 1; k < NUM_BARS; k++) begin : g_edge
        assign past_edge[k-1] = h_ext >= CMP_W'(bar_edge(mode, 4'(k)));
    end

    always_comb begin
        bar_idx = '0;
        for (int i = 0; i < NUM_BARS - 1; i++) begin
            bar_idx = bar_idx + BAR_IDX_W'(past_edge[i]);
        end
    end

    assign win_active = (h_ext >= CMP_W'(bar_edge(mode, 4'd0))) &&
                        (h_ext <  CMP_W'(bar_edge(mode, 4'(NUM_BARS))));

endmodule

// File: rtl/cbar_color_rom.sv
module cbar_color_rom
    import cbar_pkg::*;
(
    input  logic                 use_bar,
    input  logic [BAR_IDX_W-1:0] bar_idx,
    input  logic [2:0]           ovl_rgb,
    output yuv_t                 full
);

    logic [2:0] rgb_sel;

    always_comb begin
        rgb_sel = use_bar ? bar_to_rgb(bar_idx) : ovl_rgb;
        full    = rgb_to_yuv(rgb_sel);
    end

endmodule

// File: rtl/cbar_scaler.sv
module cbar_scaler
    import cbar_pkg::*;
(
    input  yuv_t       full,
    input  logic [1:0] lvl,
    output yuv_t       scaled
);

    logic [2:0]        mul;
    logic [9:0]        yprod;
    logic signed [9:0] uprod;
    logic signed [9:0] vprod;

    always_comb begin
        mul    = 3'({1'b0, lvl}) + 3'd1;
        yprod  = 10'(full.y - BLACK_Y) * 10'(mul);
        uprod  = $signed({{2{full.u[7]}}, full.u}) * $signed({7'b0, mul});
        vprod  = $signed({{2{full.v[7]}}, full.v}) * $signed({7'b0, mul});
        scaled.y = BLACK_Y + yprod[9:2];
        scaled.u = uprod[9:2];
        scaled.v = vprod[9:2];
    end

endmodule

// File: rtl/cbar_ovl_sel.sv
module cbar_ovl_sel
    import cbar_pkg::*;
#(
    parameter int HCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HCNT_W-1:0] hcount,
    input  logic [2:0]        mode,
    input  logic              ovl_r,
    input  logic              ovl_g,
    input  logic              ovl_b,
    input  logic              ovl_en,
    input  logic              bar_en,
    input  logic [1:0]        lvl,
    input  logic [7:0]        y_in,
    input  logic [7:0]        cb_in,
    input  logic [7:0]        cr_in,
    output logic [7:0]        y_out,
    output logic [7:0]        u_out,
    output logic [7:0]        v_out
);

    localparam yuv_t BLACK = {BLACK_Y, 8'h00, 8'h00};

    logic                 win_active;
    logic [BAR_IDX_W-1:0] bar_idx;
    yuv_t                 full_c;
    yuv_t                 gen_c;
    yuv_t                 gen_q;
    yuv_t                 live_q;
    yuv_t                 sel_c;
    src_e                 src_q;
    src_e                 src_d;

    cbar_locator #(.HCNT_W(HCNT_W)) u_locator (
        .hcount     (hcount),
        .mode       (mode),
        .win_active (win_active),
        .bar_idx    (bar_idx)
    );

    cbar_color_rom u_rom (
        .use_bar (bar_en),
        .bar_idx (bar_idx),
        .ovl_rgb ({ovl_r, ovl_g, ovl_b}),
        .full    (full_c)
    );

    cbar_scaler u_scaler (
        .full   (full_c),
        .lvl    (lvl),
        .scaled (gen_c)
    );

    // Next source: bar over overlay over live; generated sources blank outside window.
    always_comb begin
        src_d = SRC_LIVE;
        unique casez ({bar_en, ovl_en})
            2'b1?:   src_d = win_active ? SRC_BAR : SRC_BLANK;
            2'b01:   src_d = win_active ? SRC_OVL : SRC_BLANK;
            2'b00:   src_d = SRC_LIVE;
            default: src_d = SRC_LIVE;
        endcase
    end

    // State register, with the data captured alongside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_BLANK;
            gen_q  <= BLACK;
            live_q <= BLACK;
        end else begin
            src_q  <= src_d;
            gen_q  <= gen_c;
            live_q <= {y_in, cb_in ^ 8'h80, cr_in ^ 8'h80};
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        sel_c = BLACK;
        unique case (src_q)
            SRC_LIVE:  sel_c = live_q;
            SRC_OVL:   sel_c = gen_q;
            SRC_BAR:   sel_c = gen_q;
            SRC_BLANK: sel_c = BLACK;
            default:   sel_c = BLACK;
        endcase
    end

    assign y_out = sel_c.y;
    assign u_out = sel_c.u;
    assign v_out = sel_c.v;

endmodule

// File: rtl/cbar_ovl_sel_chk.sv
module cbar_ovl_sel_chk #(
    parameter int HCNT_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HCNT_W-1:0] hcount,
    input logic [2:0]        mode,
    input logic              ovl_en,
    input logic              bar_en,
    input logic [1:0]        lvl,
    input logic [7:0]        y_in,
    input logic [7:0]        cb_in,
    input logic [7:0]        cr_in,
    input logic [7:0]        y_out,
    input logic [7:0]        u_out,
    input logic [7:0]        v_out
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R4 / R2: live path one cycle later, chroma sign bit flipped
    p_live_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!bar_en && !ovl_en)) |->
            (y_out == $past(y_in) && u_out == ($past(cb_in) ^ 8'h80) &&
             v_out == ($past(cr_in) ^ 8'h80)));

    // R3 / R5: first bar of mode 000 at full level is white, whatever the overlay enable
    p_bar_white_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bar_en) && $past(lvl) == 2'd3 && $past(mode) == 3'd0 &&
         $past(hcount) >= HCNT_W'(127) && $past(hcount) < HCNT_W'(216)) |->
            (y_out == 8'd235 && u_out == 8'h00 && v_out == 8'h00));

    // R7: generated sources are black before any mode's window start
    p_blank_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bar_en || ovl_en) && $past(hcount) < HCNT_W'(100)) |->
            (y_out == 8'd16 && u_out == 8'h00 && v_out == 8'h00));

    // R9: generated luminance stays in the legal range
    p_luma_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bar_en || ovl_en)) |->
            (y_out >= 8'd16 && y_out <= 8'd235));

    // R9: generated chroma stays within +/-112
    p_chroma_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bar_en || ovl_en)) |->
            ($signed(u_out) >= -8'sd112 && $signed(u_out) <= 8'sd112 &&
             $signed(v_out) >= -8'sd112 && $signed(v_out) <= 8'sd112));

endmodule

bind cbar_ovl_sel cbar_ovl_sel_chk #(.HCNT_W(HCNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .hcount (hcount),
    .mode   (mode),
    .ovl_en (ovl_en),
    .bar_en (bar_en),
    .lvl    (lvl),
    .y_in   (y_in),
    .cb_in  (cb_in),
    .cr_in  (cr_in),
    .y_out  (y_out),
    .u_out  (u_out),
    .v_out  (v_out)
);

// File: tb/tb_cbar_ovl_sel.sv
module tb_cbar_ovl_sel;

    localparam int CLK_NS = 10;
    localparam int HW     = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] hcount = '0;
    logic [2:0]    mode = '0;
    logic          ovl_r = 0, ovl_g = 0, ovl_b = 0, ovl_en = 0, bar_en = 0;
    logic [1:0]    lvl = 2'd3;
    logic [7:0]    y_in = 8'd16, cb_in = 8'd128, cr_in = 8'd128;
    logic [7:0]    y_out, u_out, v_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    typedef struct {
        int    y;
        int    u;
        int    v;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_NS/2) clk = ~clk;

    cbar_ovl_sel #(.HCNT_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .mode(mode),
        .ovl_r(ovl_r), .ovl_g(ovl_g), .ovl_b(ovl_b), .ovl_en(ovl_en),
        .bar_en(bar_en), .lvl(lvl), .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .y_out(y_out), .u_out(u_out), .v_out(v_out)
    );

    // Reference tables written from the requirements
    int st_t [5]  = '{127, 116, 135, 142, 155};
    int len_t [5] = '{858, 780, 910, 864, 944};
    int ed_t [5][7] = '{'{216, 305, 394, 483, 572, 661, 750},
                        '{197, 278, 359, 440, 521, 602, 682},
                        '{230, 325, 419, 513, 607, 701, 795},
                        '{230, 318, 406, 494, 582, 670, 757},
                        '{251, 347, 443, 539, 635, 731, 827}};
    int order_t [8] = '{7, 6, 3, 2, 5, 4, 1, 0};
    int py [8] = '{16, 41, 145, 170, 81, 106, 210, 235};
    int pu [8] = '{0, 112, -74, 38, -38, 74, -112, 0};
    int pv [8] = '{0, -18, -94, -112, 112, 94, 18, 0};
    int codes [5] = '{0, 1, 2, 4, 5};

    function automatic int mode_row(input int m);
        case (m)
            1: return 1;
            2: return 2;
            4: return 3;
            5: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic exp_t model(input string tag);
        exp_t e;
        int   r, h, bi, c, k;
        e.tag = tag;
        if (!bar_en && !ovl_en) begin
            e.y = int'(y_in);
            e.u = int'(cb_in) - 128;
            e.v = int'(cr_in) - 128;
            return e;
        end
        r = mode_row(int'(mode));
        h = int'(hcount);
        if (h < st_t[r] || h >= len_t[r]) begin
            e.y = 16; e.u = 0; e.v = 0;
            return e;
        end
        if (bar_en) begin
            bi = 0;
            for (int i = 0; i < 7; i++) if (h >= ed_t[r][i]) bi++;
            c = order_t[bi];
        end else begin
            c = {29'd0, ovl_r, ovl_g, ovl_b};
        end
        k = int'(lvl) + 1;
        e.y = 16 + (((py[c] - 16) * k) >>> 2);
        e.u = (pu[c] * k) >>> 2;
        e.v = (pv[c] * k) >>> 2;
        return e;
    endfunction

    task automatic chk(input string tag, input int ay, au, av, ey, eu, ev);
        checks++;
        if (ay != ey || au != eu || av != ev) begin
            errors++;
            $display("FAIL %s: got Y/U/V %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, ay, au, av, ey, eu, ev);
        end
    endtask

    // Driver: inputs already set at a falling edge; push expectation, advance.
    task automatic step(input string tag);
        sb.push_back(model(tag));
        @(negedge clk);
    endtask

    // Monitor: result appears just after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, int'(y_out), int'($signed(u_out)), int'($signed(v_out)),
                    e.y, e.u, e.v);
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with generators enabled to show they are masked
        bar_en = 1; hcount = HW'(200);
        repeat (3) @(negedge clk);
        chk("R1 reset black", int'(y_out), int'($signed(u_out)), int'($signed(v_out)), 16, 0, 0);
        bar_en = 0;
        rst_n = 1;

        // R4 / R2: live patterns changing every cycle
        y_in = 8'd0;   cb_in = 8'd0;   cr_in = 8'd255; step("R4 live extremes");
        y_in = 8'd255; cb_in = 8'd255; cr_in = 8'd0;   step("R4 live extremes b");
        y_in = 8'd128; cb_in = 8'd128; cr_in = 8'd127; step("R2 live next cycle");
        y_in = 8'd77;  cb_in = 8'd16;  cr_in = 8'd240; step("R2 live next cycle b");

        // R5 / R6 / R7: every edge in every mode, at full level
        bar_en = 1; lvl = 2'd3;
        for (int mi = 0; mi < 5; mi++) begin
            mode = 3'(codes[mi]);
            hcount = HW'(st_t[mi] - 1); step("R7 before start");
            hcount = HW'(st_t[mi]);     step("R6 window start");
            for (int j = 0; j < 7; j++) begin
                hcount = HW'(ed_t[mi][j] - 1); step("R5 last sample of bar");
                hcount = HW'(ed_t[mi][j]);     step("R6 bar edge");
            end
            hcount = HW'(len_t[mi] - 1); step("R5 last sample of line");
            hcount = HW'(len_t[mi]);     step("R7 at line length");
        end

        // R6: unused codes behave as 000
        for (int c = 3; c < 8; c++) begin
            if (c == 4 || c == 5) continue;
            mode = 3'(c);
            hcount = HW'(126); step("R6 unused code start-1");
            hcount = HW'(127); step("R6 unused code start");
            hcount = HW'(305); step("R6 unused code edge");
            hcount = HW'(857); step("R6 unused code last");
        end

        // R8: overlay colors, R9 levels
        mode = 3'b000; bar_en = 0; ovl_en = 1; hcount = HW'(400);
        for (int l = 0; l < 4; l++) begin
            lvl = 2'(l);
            for (int c = 0; c < 8; c++) begin
                {ovl_r, ovl_g, ovl_b} = 3'(c);
                step("R8 R9 overlay color");
            end
        end

        // R9: bar scaling, every bar at each level in mode 101
        bar_en = 1; ovl_en = 0; mode = 3'b101;
        for (int l = 0; l < 4; l++) begin
            lvl = 2'(l);
            hcount = HW'(160);
            step("R9 bar level");
            for (int j = 0; j < 7; j++) begin
                hcount = HW'(ed_t[4][j] + 3);
                step("R9 bar level");
            end
        end

        // R3: priority
        lvl = 2'd3; mode = 3'b000; hcount = HW'(480);
        {ovl_r, ovl_g, ovl_b} = 3'b001;
        bar_en = 1; ovl_en = 1; step("R3 bar over overlay");
        bar_en = 0; ovl_en = 1; step("R3 overlay over live");
        bar_en = 0; ovl_en = 0; y_in = 8'd99; cb_in = 8'd3; cr_in = 8'd200;
        step("R3 live when both off");
        bar_en = 0; ovl_en = 1; hcount = HW'(20); step("R7 overlay blanked");
        bar_en = 1; ovl_en = 1; hcount = HW'(860); step("R7 bar blanked past line");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule